// File: doc/BRIEF.md
# Per-Core Interrupt Concentrator

This block gathers three classes of interrupt source for a small group of cores and drives one interrupt line per core. The classes are level-sensitive hardware input lines, software mailboxes that a bus write raises and a bus read acknowledges, and periodic timers with a period counted in clock cycles. Each core output has its own enable mask for each class. A single status word per output gives the winner of each class: the lowest-numbered enabled pending source.

Software reaches everything through a simple 32-bit register port. The port has a write strobe, a read strobe, a word address and write data. Read data is registered and appears the cycle after the read strobe. The word address carries a 4-bit function code above a 5-bit index. The index selects an output, a mailbox or a timer, depending on the function. A read-only configuration word reports how many sources of each class the instance was built with.

Top module: `irq_hub`

## Requirements
- R1: After reset all masks are 0, no mailbox or timer is pending, every timer period is 0, `core_irq` is all low and `bus_rdata` is 0.
- R2: The word address is `{func[3:0], idx[4:0]}`. The function codes are 0 for a mailbox, 1 for a timer period, 2 for a timer acknowledge, 3 for output status, 4 and 5 to set and clear a line mask, 6 and 7 to set and clear a mailbox mask, 8 and 9 to set and clear a timer mask, and 10 for configuration (idx 0).
- R3: Reading configuration returns the mailbox count in bits [23:16], the line count in [15:8], the timer count in [7:0], and zeros above.
- R4: A write to a set-mask address ORs the low bits of the word into that output's mask. A write to a clear-mask address clears the mask bits that are 1 in the word. Other bits are unchanged, and masks change only through these writes. Reading a set-mask address returns the mask; reading a clear-mask address returns 0.
- R5: Writing any value to a mailbox stores the value and makes the mailbox pending. Reading the mailbox returns the stored value and clears the pending state.
- R6: Writing period P ≥ 1 to a timer at clock edge E makes it pending at edge E+P, and again every P edges after that. A period of 0 stops the timer, so it never becomes pending. Reading the period address returns the period.
- R7: Reading a timer's acknowledge address clears its pending state. If the timer expires on the same edge, it stays pending.
- R8: The status word has bit 2 for a mailbox winner, bit 1 for a line winner and bit 0 for a timer winner. The winners' indices sit in bits [28:24], [20:16] and [12:8]. A field is 0 when its class has no winner, and all other bits are 0.
- R9: Within each class the winner is the lowest-numbered source that is both pending and enabled in that output's mask. Masked sources never appear.
- R10: `core_irq[k]` is high exactly when any of output k's three status flags is set.
- R11: `bus_rdata` updates only on the edge where `bus_rd` is high and holds its value otherwise.
- R12: Accesses to an index beyond the built count, or to an unused function code, change nothing and read back as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 9 | Word address {func, idx} |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| hw_irq | input | N_HW | Level-sensitive hardware interrupt lines |
| core_irq | output | N_OUT | Interrupt line per core output |

## Verification
The bound checker checks on every cycle that each core line agrees with the enabled pending sources of its output. It also checks that a mailbox write leaves the mailbox pending, that a mailbox read clears it, that masks move only on writes, that a stopped timer never rises, and that read data holds between reads. The exact expiry cycle of a timer, its periodic reload, the acknowledge/expiry collision, and the encoded winners in the status word are shown only by the bench's scenarios. The bench sweeps every line pattern against several masks on every output.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int FUNC_W = 4;
  localparam int IDX_W  = 5;
  localparam int ADDR_W = FUNC_W + IDX_W;
  localparam int DATA_W = 32;

  typedef enum logic [FUNC_W-1:0] {
    F_MBOX   = 4'd0,
    F_PERIOD = 4'd1,
    F_TACK   = 4'd2,
    F_STATUS = 4'd3,
    F_HW_SET = 4'd4,
    F_HW_CLR = 4'd5,
    F_MB_SET = 4'd6,
    F_MB_CLR = 4'd7,
    F_TM_SET = 4'd8,
    F_TM_CLR = 4'd9,
    F_CONFIG = 4'd10
  } func_e;

  typedef struct packed {
    logic             hit;
    logic [IDX_W-1:0] idx;
  } winner_t;

  // Status layout: class flags in the low bits, winner indices in byte lanes.
  function automatic logic [DATA_W-1:0] pack_status(winner_t mb, winner_t hw, winner_t tm);
    logic [DATA_W-1:0] w;
    w        = '0;
    w[28:24] = mb.hit ? mb.idx : '0;
    w[20:16] = hw.hit ? hw.idx : '0;
    w[12:8]  = tm.hit ? tm.idx : '0;
    w[2]     = mb.hit;
    w[1]     = hw.hit;
    w[0]     = tm.hit;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] pack_config(int n_mb, int n_hw, int n_tm);
    return {8'd0, 8'(n_mb), 8'(n_hw), 8'(n_tm)};
  endfunction
endpackage

// File: rtl/irq_hub_lowest.sv
module irq_hub_lowest
  import irq_hub_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] req,
  output winner_t      win
);
  // Scan from the top so the lowest set bit is written last and wins.
  always_comb begin
    win = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        win.hit = 1'b1;
        win.idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/irq_hub_timer.sv
module irq_hub_timer
  import irq_hub_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_val,
  input  logic              ack,
  output logic [DATA_W-1:0] period,
  output logic              pend
);
  logic [DATA_W-1:0] cnt_q;
  logic              running;
  logic              expire;

  assign running = (period != '0) && !load;
  assign expire  = running && (cnt_q <= DATA_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      period <= '0;
      cnt_q  <= '0;
      pend   <= 1'b0;
    end else begin
      if (load) begin
        period <= load_val;
        cnt_q  <= load_val;
      end else if (running) begin
        cnt_q <= expire ? period : cnt_q - DATA_W'(1);
      end
      if (expire)   pend <= 1'b1;
      else if (ack) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irq_hub_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int N_HW  = 8,
  parameter int N_MB  = 8,
  parameter int N_TM  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [N_HW-1:0]   hw_irq,
  output logic [N_OUT-1:0]  core_irq
);
  localparam int OW = (N_OUT > 1) ? $clog2(N_OUT) : 1;
  localparam int MW = (N_MB  > 1) ? $clog2(N_MB)  : 1;
  localparam int TW = (N_TM  > 1) ? $clog2(N_TM)  : 1;

  // Address decode
  func_e            func;
  logic [IDX_W-1:0] idx;
  logic             out_ok, mb_ok, tm_ok;
  logic [OW-1:0]    oi;
  logic [MW-1:0]    mi;
  logic [TW-1:0]    ti;

  assign func   = func_e'(bus_addr[ADDR_W-1:IDX_W]);
  assign idx    = bus_addr[IDX_W-1:0];
  assign out_ok = 32'(idx) < N_OUT;
  assign mb_ok  = 32'(idx) < N_MB;
  assign tm_ok  = 32'(idx) < N_TM;
  assign oi     = idx[OW-1:0];
  assign mi     = idx[MW-1:0];
  assign ti     = idx[TW-1:0];

  // Per-output masks
  logic [N_HW-1:0] hw_mask [N_OUT];
  logic [N_MB-1:0] mb_mask [N_OUT];
  logic [N_TM-1:0] tm_mask [N_OUT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < N_OUT; k++) begin
        hw_mask[k] <= '0;
        mb_mask[k] <= '0;
        tm_mask[k] <= '0;
      end
    end else if (bus_wr && out_ok) begin
      case (func)
        F_HW_SET: hw_mask[oi] <= hw_mask[oi] |  bus_wdata[N_HW-1:0];
        F_HW_CLR: hw_mask[oi] <= hw_mask[oi] & ~bus_wdata[N_HW-1:0];
        F_MB_SET: mb_mask[oi] <= mb_mask[oi] |  bus_wdata[N_MB-1:0];
        F_MB_CLR: mb_mask[oi] <= mb_mask[oi] & ~bus_wdata[N_MB-1:0];
        F_TM_SET: tm_mask[oi] <= tm_mask[oi] |  bus_wdata[N_TM-1:0];
        F_TM_CLR: tm_mask[oi] <= tm_mask[oi] & ~bus_wdata[N_TM-1:0];
        default: ;
      endcase
    end
  end

  // Mailboxes: named select events, then storage
  logic [N_MB-1:0]   mb_wr_sel, mb_rd_sel, mb_pend;
  logic [DATA_W-1:0] mb_val [N_MB];

  for (genvar m = 0; m < N_MB; m++) begin : g_mbsel
    assign mb_wr_sel[m] = bus_wr && (func == F_MBOX) && (idx == IDX_W'(m));
    assign mb_rd_sel[m] = bus_rd && (func == F_MBOX) && (idx == IDX_W'(m));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mb_pend <= '0;
      for (int m = 0; m < N_MB; m++) mb_val[m] <= '0;
    end else begin
      for (int m = 0; m < N_MB; m++) begin
        if (mb_wr_sel[m]) begin
          mb_val[m]  <= bus_wdata;
          mb_pend[m] <= 1'b1;
        end else if (mb_rd_sel[m]) begin
          mb_pend[m] <= 1'b0;
        end
      end
    end
  end

  // Timers
  logic [N_TM-1:0]   tm_pend;
  logic [DATA_W-1:0] tm_period [N_TM];

  for (genvar t = 0; t < N_TM; t++) begin : g_tmr
    irq_hub_timer u_tmr (
      .clk      (clk),
      .rst      (rst),
      .load     (bus_wr && (func == F_PERIOD) && (idx == IDX_W'(t))),
      .load_val (bus_wdata),
      .ack      (bus_rd && (func == F_TACK) && (idx == IDX_W'(t))),
      .period   (tm_period[t]),
      .pend     (tm_pend[t])
    );
  end

  // Per-output winners and status
  logic [DATA_W-1:0] status_word [N_OUT];

  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    winner_t hw_win, mb_win, tm_win;
    irq_hub_lowest #(.W(N_HW)) u_hw (.req(hw_irq  & hw_mask[k]), .win(hw_win));
    irq_hub_lowest #(.W(N_MB)) u_mb (.req(mb_pend & mb_mask[k]), .win(mb_win));
    irq_hub_lowest #(.W(N_TM)) u_tm (.req(tm_pend & tm_mask[k]), .win(tm_win));
    assign status_word[k] = pack_status(mb_win, hw_win, tm_win);
    assign core_irq[k]    = mb_win.hit | hw_win.hit | tm_win.hit;
  end

  // Read path
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    case (func)
      F_MBOX:           if (mb_ok)  rd_mux = mb_val[mi];
      F_PERIOD, F_TACK: if (tm_ok)  rd_mux = tm_period[ti];
      F_STATUS:         if (out_ok) rd_mux = status_word[oi];
      F_HW_SET:         if (out_ok) rd_mux = DATA_W'(hw_mask[oi]);
      F_MB_SET:         if (out_ok) rd_mux = DATA_W'(mb_mask[oi]);
      F_TM_SET:         if (out_ok) rd_mux = DATA_W'(tm_mask[oi]);
      F_CONFIG:         if (idx == '0) rd_mux = pack_config(N_MB, N_HW, N_TM);
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
  end
endmodule

// File: rtl/irq_hub_checker.sv
module irq_hub_checker
  import irq_hub_pkg::*;
#(
  parameter int N_OUT = 4,
  parameter int N_HW  = 8,
  parameter int N_MB  = 8,
  parameter int N_TM  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [N_HW-1:0]   hw_irq,
  input logic [N_OUT-1:0]  core_irq,
  input logic [N_HW-1:0]   hw_mask [N_OUT],
  input logic [N_MB-1:0]   mb_mask [N_OUT],
  input logic [N_TM-1:0]   tm_mask [N_OUT],
  input logic [N_MB-1:0]   mb_pend,
  input logic [N_TM-1:0]   tm_pend,
  input logic [DATA_W-1:0] tm_period [N_TM]
);
  for (genvar k = 0; k < N_OUT; k++) begin : g_out
    assert_irq_follows_sources_R10: assert property (@(posedge clk) disable iff (rst)
      core_irq[k] == ((|(hw_irq & hw_mask[k])) || (|(mb_pend & mb_mask[k])) ||
                      (|(tm_pend & tm_mask[k]))));
    assert_masks_hold_without_write_R4: assert property (@(posedge clk) disable iff (rst)
      !bus_wr |=> ($stable(hw_mask[k]) && $stable(mb_mask[k]) && $stable(tm_mask[k])));
  end

  for (genvar m = 0; m < N_MB; m++) begin : g_mb
    assert_mbox_write_pends_R5: assert property (@(posedge clk) disable iff (rst)
      (bus_wr && bus_addr == ADDR_W'(m)) |=> mb_pend[m]);
    assert_mbox_read_clears_R5: assert property (@(posedge clk) disable iff (rst)
      (bus_rd && !bus_wr && bus_addr == ADDR_W'(m)) |=> !mb_pend[m]);
  end

  for (genvar t = 0; t < N_TM; t++) begin : g_tm
    assert_stopped_timer_quiet_R6: assert property (@(posedge clk) disable iff (rst)
      $rose(tm_pend[t]) |-> $past(tm_period[t]) != '0);
  end

  assert_rdata_holds_R11: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind irq_hub irq_hub_checker #(
  .N_OUT(N_OUT), .N_HW(N_HW), .N_MB(N_MB), .N_TM(N_TM)
) u_chk (.*);

// File: tb/irq_hub_test.sv
module irq_hub_test;
  localparam int N_OUT = 4;
  localparam int N_HW  = 8;
  localparam int N_MB  = 8;
  localparam int N_TM  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0;
  logic              bus_rd = 1'b0;
  logic [8:0]        bus_addr = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic [N_HW-1:0]   hw_irq = '0;
  logic [N_OUT-1:0]  core_irq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  irq_hub #(.N_OUT(N_OUT), .N_HW(N_HW), .N_MB(N_MB), .N_TM(N_TM)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_irq(hw_irq), .core_irq(core_irq)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(int f, int i, logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 9'(f * 32 + i); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(int f, int i, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = 9'(f * 32 + i);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  function automatic int lowest(logic [31:0] v);
    for (int i = 0; i < 32; i++) if (v[i]) return i;
    return -1;
  endfunction

  // Expected status: flags 4/2/1, indices times 2^24, 2^16, 2^8
  function automatic logic [31:0] exp_status(int mb, int hw, int tm);
    longint s = 0;
    if (mb >= 0) s += 4 + mb * 64'd16777216;
    if (hw >= 0) s += 2 + hw * 64'd65536;
    if (tm >= 0) s += 1 + tm * 64'd256;
    return 32'(s);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [7:0] masks [4];
    bit stayed_low;
    masks[0] = 8'hFF; masks[1] = 8'hA5; masks[2] = 8'h3C; masks[3] = 8'h80;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check("R1 core_irq", 32'(core_irq), 0);
    check("R1 rdata", bus_rdata, 0);
    for (int k = 0; k < N_OUT; k++) begin
      rd(3, k, d); check("R1 status", d, 0);
      rd(4, k, d); check("R1 line mask", d, 0);
      rd(6, k, d); check("R1 mbox mask", d, 0);
      rd(8, k, d); check("R1 timer mask", d, 0);
    end
    for (int t = 0; t < N_TM; t++) begin
      rd(1, t, d); check("R1 period", d, 0);
    end
    wr(6, 0, 32'hFF); wr(8, 0, 32'hF);
    rd(3, 0, d); check("R1 nothing pending", d, 0);
    wr(7, 0, 32'hFF); wr(9, 0, 32'hF);

    // R3/R2 configuration, R11 hold
    rd(10, 0, d); check("R3 R2 config", d, 32'h00080804);
    repeat (5) @(negedge clk);
    wr(0, 7, 32'h1234);
    check("R11 rdata held", bus_rdata, 32'h00080804);
    rd(0, 7, d);

    // R4 mask set/clear
    wr(4, 2, 32'h0F); rd(4, 2, d); check("R4 set", d, 32'h0F);
    wr(4, 2, 32'h30); rd(4, 2, d); check("R4 set keeps", d, 32'h3F);
    wr(5, 2, 32'h1C); rd(4, 2, d); check("R4 clear", d, 32'h23);
    rd(5, 2, d); check("R4 clear addr reads 0", d, 0);
    wr(6, 1, 32'hFF); wr(7, 1, 32'hAA); rd(6, 1, d); check("R4 mbox mask", d, 32'h55);
    wr(8, 3, 32'hF); wr(9, 3, 32'h9); rd(8, 3, d); check("R4 timer mask", d, 32'h6);
    for (int k = 0; k < N_OUT; k++) begin
      wr(5, k, 32'hFF); wr(7, k, 32'hFF); wr(9, k, 32'hF);
    end

    // R8/R9/R10 line sweep
    for (int k = 0; k < N_OUT; k++) begin
      wr(4, k, 32'(masks[k]));
      for (int p = 0; p < 256; p++) begin
        @(negedge clk);
        hw_irq = 8'(p);
        rd(3, k, d);
        check("R9 R8 line winner", d, exp_status(-1, lowest(32'(8'(p) & masks[k])), -1));
        check("R10 line irq", 32'(core_irq[k]), 32'((8'(p) & masks[k]) != 0));
      end
      wr(5, k, 32'hFF);
    end
    @(negedge clk);
    hw_irq = '0;

    // R5 mailboxes
    wr(6, 1, 32'hFF);
    wr(0, 5, 32'hCAFE0005);
    rd(3, 1, d); check("R5 R8 mbox pending", d, exp_status(5, -1, -1));
    check("R10 own output", 32'(core_irq), 32'b0010);
    wr(0, 2, 32'hBEEF0002);
    rd(3, 1, d); check("R9 lower mbox wins", d, exp_status(2, -1, -1));
    rd(0, 2, d); check("R5 read value", d, 32'hBEEF0002);
    rd(3, 1, d); check("R5 read clears", d, exp_status(5, -1, -1));
    rd(0, 2, d); check("R5 value kept", d, 32'hBEEF0002);
    rd(3, 1, d); check("R5 stays clear", d, exp_status(5, -1, -1));
    wr(7, 1, 32'h20);
    rd(3, 1, d); check("R9 masked mbox hidden", d, 0);
    check("R10 masked irq low", 32'(core_irq), 0);
    rd(0, 5, d); check("R5 read value 5", d, 32'hCAFE0005);
    wr(6, 1, 32'h20);
    rd(3, 1, d); check("R5 cleared after read", d, 0);

    // R12 out of range and unused codes
    wr(0, 20, 32'h1);
    rd(3, 1, d); check("R12 mbox idx ignored", d, 0);
    rd(0, 20, d); check("R12 mbox idx reads 0", d, 0);
    wr(4, 9, 32'hFF);
    rd(4, 9, d); check("R12 output idx reads 0", d, 0);
    wr(15, 0, 32'hFFFF);
    rd(15, 0, d); check("R12 unused code reads 0", d, 0);
    rd(10, 0, d); check("R12 config intact", d, 32'h00080804);
    wr(7, 1, 32'hFF);

    // R6/R7 timers, period 8 on timer 1, timer 2 left stopped
    wr(8, 0, 32'h6);
    wr(1, 1, 32'd8);                  // takes effect on edge E0
    check("R6 before expiry", 32'(core_irq[0]), 0);
    stayed_low = 1;
    for (int c = 1; c < 8; c++) begin
      @(negedge clk);
      if (core_irq[0]) stayed_low = 0;
    end
    check("R6 low until E8", 32'(stayed_low), 1);
    @(negedge clk);
    check("R6 pending at E8", 32'(core_irq[0]), 1);
    rd(3, 0, d); check("R8 timer status", d, exp_status(-1, -1, 1));
    rd(1, 1, d); check("R6 period readback", d, 8);
    check("R7 pending before ack", 32'(core_irq[0]), 1);
    rd(2, 1, d);                        // ack on E14? see below
    check("R7 ack clears", 32'(core_irq[0]), 0);
    // Status read edge E10, period read E12, ack E14; next expiry E16
    @(negedge clk);
    check("R6 low before reload expiry", 32'(core_irq[0]), 0);
    @(negedge clk);
    check("R6 periodic expiry at E16", 32'(core_irq[0]), 1);
    repeat (6) @(negedge clk);          // now after E22
    rd(2, 1, d);                        // ack on E24, same edge as expiry
    check("R7 expiry wins over ack", 32'(core_irq[0]), 1);
    rd(2, 1, d);
    check("R7 second ack clears", 32'(core_irq[0]), 0);
    wr(1, 1, 32'd0);
    stayed_low = 1;
    for (int c = 0; c < 40; c++) begin
      @(negedge clk);
      if (core_irq[0]) stayed_low = 0;
    end
    check("R6 period 0 stops", 32'(stayed_low), 1);
    rd(3, 0, d); check("R6 stopped timer 2 never pends", d, 0);
    rd(1, 2, d); check("R6 stopped period", d, 0);

    finish_run();
  end
endmodule